// File: doc/BRIEF.md
# Segmented Complex Sample Buffer

This block holds 64 complex words, each a 16-bit in-phase part and a 16-bit quadrature part, in one shared memory that is split at run time into one, two or four circular segments. Each segment serves one resampling channel. Toward its writer a segment behaves as a FIFO: it raises a per-channel request while it has room, and it takes one complex word per write strobe. Toward the filter engine the same segment is a delay line. The engine reads any history tap by channel and by offset back from the newest word, and the word arrives one clock later.

When the filter engine has finished with old samples, it passes a consume count for a channel. The count retires that many of the oldest retained words and frees room for new input. Changing the segment-count setting empties every segment and rewinds every pointer, so the new partition starts clean.

Top module: `cplx_seg_buf`

## Requirements
- R1: After reset, with the segment-count setting at 00, reqOut equals 4'b0001 and rdValid is 0.
- R2: The segment-count setting chanMode selects the partition. 00 gives one segment of 64 words, 01 gives two segments of 32 words, and 10 or 11 gives four segments of 16 words. Only channels below the segment count are active. An inactive channel keeps its request low and ignores writes.
- R3: A channel's request is high exactly when the channel is active and its occupancy is below the segment size. A write to a channel whose request is low is dropped and changes neither stored data nor occupancy.
- R4: A read with rdEn, rdChan and rdTap returns, on the next clock with rdValid high, the word written rdTap accepted writes before that channel's newest word. The tap is taken modulo the segment size.
- R5: A consume with count n on a channel lowers its occupancy by n, or by the whole occupancy when n exceeds it, so the request rises again.
- R6: When a write and a consume reach the same channel in the same cycle, the write is accepted only if the occupancy before that cycle is below the segment size. The new occupancy is the old one, plus one for an accepted write, minus the retired count.
- R7: A change of chanMode clears the occupancy and write position of every channel, and a write in the cycle of the change is discarded.
- R8: Writes, reads and consumes on one channel leave the data and occupancy of every other channel unchanged.
- R9: A read issued in the same cycle as an accepted write to the same channel uses the channel state before that write, so tap 0 returns the previous newest word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanMode | input | 2 | Segment-count setting |
| wrValid | input | 1 | Write strobe for one complex word |
| wrChan | input | 2 | Channel addressed by the write |
| wrI | input | 16 | In-phase part of the written word |
| wrQ | input | 16 | Quadrature part of the written word |
| rdEn | input | 1 | Delay-line read strobe |
| rdChan | input | 2 | Channel addressed by the read |
| rdTap | input | 6 | Offset back from the newest word |
| consEn | input | 1 | Consume strobe |
| consChan | input | 2 | Channel addressed by the consume |
| consCount | input | 7 | Number of oldest words to retire |
| reqOut | output | 4 | Per-channel request for another input word |
| rdValid | output | 1 | Read data valid, one clock after rdEn |
| rdI | output | 16 | In-phase part of the read word |
| rdQ | output | 16 | Quadrature part of the read word |

## Verification
A write and a consume can reach the same channel in the same cycle. The bench provokes this in two ways: on a full segment, where the write must still be refused, and on an empty segment with a consume count larger than the occupancy, where the write must be kept and the retire must saturate at zero. Each case is judged by writing further words until the request falls and checking that it falls after exactly the predicted number. A read and a write on one channel can also coincide. There, tap 0 must return the word that was newest before the cycle.

// File: rtl/csb_pkg.sv
package csb_pkg;
  localparam int DW     = 16;
  localparam int DEPTH  = 64;
  localparam int NCH    = 4;
  localparam int AW     = $clog2(DEPTH);
  localparam int CW     = $clog2(NCH);
  localparam int LOG_NCH = $clog2(NCH);
  localparam int MW     = 2;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] waddr;
    logic          re;
    logic [AW-1:0] raddr;
  } memStrobe_t;
endpackage

// File: rtl/csb_ctrl.sv
module csb_ctrl
  import csb_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [MW-1:0]  chanMode,
  input  logic           wrValid,
  input  logic [CW-1:0]  wrChan,
  input  logic           rdEn,
  input  logic [CW-1:0]  rdChan,
  input  logic [AW-1:0]  rdTap,
  input  logic           consEn,
  input  logic [CW-1:0]  consChan,
  input  logic [AW:0]    consCount,
  output logic [NCH-1:0] reqOut,
  output memStrobe_t     strobe
);
  logic [MW-1:0] modeQ;
  logic [AW:0]   occ     [NCH];
  logic [AW-1:0] wrPtr   [NCH];
  logic [AW:0]   occNext [NCH];
  logic [AW-1:0] ptrNext [NCH];
  logic [NCH-1:0] chActive;

  int            segLog;
  int            segBits;
  logic [AW:0]   segSize;
  logic [AW-1:0] segMask;
  logic          modeChg;
  logic          accept;

  always_comb begin
    segLog  = (int'(modeQ) > LOG_NCH) ? LOG_NCH : int'(modeQ);
    segBits = AW - segLog;
    segSize = (AW+1)'(1) << segBits;
    segMask = AW'(segSize - (AW+1)'(1));
    modeChg = (chanMode != modeQ);
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      chActive[c] = (c < (1 << segLog));
      reqOut[c]   = chActive[c] && (occ[c] < segSize);
    end
    accept = wrValid && reqOut[wrChan] && !modeChg;
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      logic          wrHit;
      logic          consHit;
      logic [AW:0]   retire;
      wrHit   = accept && (wrChan == CW'(c));
      consHit = consEn && (consChan == CW'(c)) && chActive[c] && !modeChg;
      retire  = '0;
      if (consHit) retire = (consCount > occ[c]) ? occ[c] : consCount;
      occNext[c] = occ[c] + {{AW{1'b0}}, wrHit} - retire;
      ptrNext[c] = wrHit ? ((wrPtr[c] + AW'(1)) & segMask) : wrPtr[c];
      if (modeChg) begin
        occNext[c] = '0;
        ptrNext[c] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
      for (int c = 0; c < NCH; c++) begin
        occ[c]   <= '0;
        wrPtr[c] <= '0;
      end
    end else begin
      modeQ <= chanMode;
      for (int c = 0; c < NCH; c++) begin
        occ[c]   <= occNext[c];
        wrPtr[c] <= ptrNext[c];
      end
    end
  end

  always_comb begin
    strobe.we    = accept;
    strobe.waddr = (AW'(wrChan) << segBits) | wrPtr[wrChan];
    strobe.re    = rdEn;
    strobe.raddr = (AW'(rdChan) << segBits)
                 | ((wrPtr[rdChan] - AW'(1) - rdTap) & segMask);
  end

  for (genvar g = 0; g < NCH; g++) begin : gChk
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      occ[g] <= segSize); // R3
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (!reqOut[g] && !(consEn && consChan == CW'(g)) && chanMode == modeQ)
      |=> occ[g] == $past(occ[g])); // R3
    AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      (chanMode != modeQ) |=> (occ[g] == '0 && wrPtr[g] == '0)); // R7
    AST_OCC_STEP: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> occ[g] <= $past(occ[g]) + (AW+1)'(1)); // R6
  end
endmodule

// File: rtl/csb_dpath.sv
module csb_dpath
  import csb_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  memStrobe_t    strobe,
  input  logic [DW-1:0] wrI,
  input  logic [DW-1:0] wrQ,
  output logic          rdValid,
  output logic [DW-1:0] rdI,
  output logic [DW-1:0] rdQ
);
  logic [2*DW-1:0] mem [DEPTH];
  logic [2*DW-1:0] rdWord;

  always_ff @(posedge clk) begin
    if (strobe.we) mem[strobe.waddr] <= {wrI, wrQ};
    if (strobe.re) rdWord <= mem[strobe.raddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= strobe.re;
  end

  assign rdI = rdWord[2*DW-1:DW];
  assign rdQ = rdWord[DW-1:0];

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.re |=> rdValid); // R4
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.re |=> !rdValid); // R4
endmodule

// File: rtl/cplx_seg_buf.sv
module cplx_seg_buf
  import csb_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [1:0]     chanMode,
  input  logic           wrValid,
  input  logic [1:0]     wrChan,
  input  logic [15:0]    wrI,
  input  logic [15:0]    wrQ,
  input  logic           rdEn,
  input  logic [1:0]     rdChan,
  input  logic [5:0]     rdTap,
  input  logic           consEn,
  input  logic [1:0]     consChan,
  input  logic [6:0]     consCount,
  output logic [3:0]     reqOut,
  output logic           rdValid,
  output logic [15:0]    rdI,
  output logic [15:0]    rdQ
);
  memStrobe_t strobe;

  csb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chanMode(chanMode),
    .wrValid(wrValid), .wrChan(wrChan),
    .rdEn(rdEn), .rdChan(rdChan), .rdTap(rdTap),
    .consEn(consEn), .consChan(consChan), .consCount(consCount),
    .reqOut(reqOut), .strobe(strobe)
  );

  csb_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrI(wrI), .wrQ(wrQ),
    .rdValid(rdValid), .rdI(rdI), .rdQ(rdQ)
  );
endmodule

// File: tb/cplx_seg_buf_bench.sv
`timescale 1ns/1ps
module cplx_seg_buf_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  chanMode = 2'b00;
  logic        wrValid = 1'b0;
  logic [1:0]  wrChan = '0;
  logic [15:0] wrI = '0, wrQ = '0;
  logic        rdEn = 1'b0;
  logic [1:0]  rdChan = '0;
  logic [5:0]  rdTap = '0;
  logic        consEn = 1'b0;
  logic [1:0]  consChan = '0;
  logic [6:0]  consCount = '0;
  logic [3:0]  reqOut;
  logic        rdValid;
  logic [15:0] rdI, rdQ;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cplx_seg_buf u_cplx_seg_buf (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wrValid = 0; rdEn = 0; consEn = 0;
  endtask

  task automatic wr(logic [1:0] ch, logic [15:0] vi, logic [15:0] vq);
    wrValid = 1; wrChan = ch; wrI = vi; wrQ = vq;
    @(negedge clk); idle();
  endtask

  task automatic rd(logic [1:0] ch, logic [5:0] tap);
    rdEn = 1; rdChan = ch; rdTap = tap;
    @(negedge clk); idle();
  endtask

  task automatic cons(logic [1:0] ch, logic [6:0] n);
    consEn = 1; consChan = ch; consCount = n;
    @(negedge clk); idle();
  endtask

  task automatic setMode(logic [1:0] m);
    chanMode = m;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reqOut", reqOut, 4'b0001);
    chk("R1 rdValid", rdValid, 0);
  endtask

  task automatic t_quad();
    setMode(2'b10);
    chk("R2 quad req", reqOut, 4'b1111);
    for (int k = 0; k < 16; k++) wr(1, 16'h0100 + k, 16'h0200 + k);
    chk("R3 full req", reqOut, 4'b1101);
    wr(1, 16'hDEAD, 16'hBEEF);
    rd(1, 0);
    chk("R3 dropped write", {rdI, rdQ}, {16'h010F, 16'h020F});
    chk("R4 rdValid", rdValid, 1);
    rd(1, 5);
    chk("R4 tap5", {rdI, rdQ}, {16'h010A, 16'h020A});
    rd(1, 16);
    chk("R4 tap modulo", rdI, 16'h010F);
    wr(2, 16'h0300, 16'h0301);
    rd(2, 0);
    chk("R8 ch2 tap0", rdI, 16'h0300);
    rd(1, 0);
    chk("R8 ch1 untouched", rdI, 16'h010F);
    chk("R8 req", reqOut, 4'b1111 & ~4'b0010);
  endtask

  task automatic t_consume();
    cons(1, 3);
    chk("R5 req reopens", reqOut[1], 1);
    for (int k = 0; k < 3; k++) wr(1, 16'h0110 + k, 0);
    chk("R5 refill", reqOut[1], 0);
    cons(2, 40);
    for (int k = 0; k < 15; k++) wr(2, 16'h0310 + k, 0);
    chk("R5 saturate partial", reqOut[2], 1);
    wr(2, 16'h031F, 0);
    chk("R5 saturate full", reqOut[2], 0);
  endtask

  task automatic t_concurrent();
    wrValid = 1; wrChan = 1; wrI = 16'h01AA; wrQ = 0;
    consEn = 1; consChan = 1; consCount = 1;
    @(negedge clk); idle();
    chk("R6 full write refused req", reqOut[1], 1);
    rd(1, 0);
    chk("R6 refused data", rdI, 16'h0112);
    wrValid = 1; wrChan = 3; wrI = 16'h0500; wrQ = 0;
    consEn = 1; consChan = 3; consCount = 5;
    @(negedge clk); idle();
    for (int k = 1; k < 15; k++) wr(3, 16'h0500 + k, 0);
    chk("R6 occ after 15", reqOut[3], 1);
    wr(3, 16'h050F, 0);
    chk("R6 occ after 16", reqOut[3], 0);
    wr(0, 16'h0050, 0);
    wrValid = 1; wrChan = 0; wrI = 16'h0051; wrQ = 0;
    rdEn = 1; rdChan = 0; rdTap = 0;
    @(negedge clk); idle();
    chk("R9 read before write", rdI, 16'h0050);
    rd(0, 0);
    chk("R9 write landed", rdI, 16'h0051);
  endtask

  task automatic t_mode();
    chanMode = 2'b01;
    wrValid = 1; wrChan = 0; wrI = 16'h0777; wrQ = 0;
    @(negedge clk); idle();
    chk("R7 two-seg req", reqOut, 4'b0011);
    for (int k = 0; k < 31; k++) wr(0, 16'h0600 + k, 0);
    chk("R7 discard write", reqOut[0], 1);
    wr(2, 16'h0999, 0);
    chk("R2 inactive ignored", reqOut, 4'b0011);
    for (int k = 0; k < 32; k++) wr(1, 16'h0400 + k, 0);
    chk("R3 32 full", reqOut[1], 0);
    cons(1, 32);
    for (int k = 32; k < 40; k++) wr(1, 16'h0400 + k, 0);
    rd(1, 0);  chk("R4 wrap tap0", rdI, 16'h0427);
    rd(1, 8);  chk("R4 wrap tap8", rdI, 16'h041F);
    rd(1, 31); chk("R4 wrap tap31", rdI, 16'h0408);
    rd(1, 32); chk("R4 wrap tap32", rdI, 16'h0427);
  endtask

  task automatic t_single();
    setMode(2'b00);
    chk("R2 single req", reqOut, 4'b0001);
    for (int k = 0; k < 64; k++) wr(0, 16'h0800 + k, 16'h0900 + k);
    chk("R3 64 full", reqOut, 4'b0000);
    rd(0, 63);
    chk("R4 tap63", {rdI, rdQ}, {16'h0800, 16'h0900});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_quad();
    t_consume();
    t_concurrent();
    t_mode();
    t_single();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule